// File: doc/BRIEF.md
# Microstep Instruction Procedure Sequencer

This block takes an 8-bit instruction that has already been fetched and plays it out as a short, fixed list of control-bus words. Each word has a 5-bit enumerator, which picks a register or an arithmetic unit, and a 2-bit parameter field. Bit 1 of the parameter marks a destination when set and a source when clear. The block knows three kinds of instruction. A register move expands to a source step followed by a destination step. The all-zero move of null to null does nothing. An increment expands to four steps that raise carry, mask the other operand, enable the adder and write the result.

Each step holds its word for a parameterised number of ticks, with a minimum of four. A derived bus clock rises on the third tick of the step, so the enumeration decoders downstream have settled by then. Between two steps the block drives the all-zero word for one tick. A one-cycle `done` pulse marks the end of a procedure. An opcode the block does not recognise, and the null move, produce no words and give `done` at once. A controller pulses `start` with an opcode while the block is idle and waits for `done`.

Top module: `microstep_sequencer`

## Requirements
- R1: During and right after reset, `busy`, `done` and `bus_clk` are low and the control word (enum, param) is 00000/00.
- R2: `start` is taken only while the block is idle (not busy). A `start` or opcode change while busy has no effect on the running procedure.
- R3: An opcode with bits [7:6] = 00, other than 0x00, issues two steps. The first is enum {00, opcode[5:3]} with param 00 (source). The second is enum {00, opcode[2:0]} with param 10 (destination).
- R4: Opcode 0x00 issues no control word. `done` is high in the cycle after the accepting edge, and `busy` stays low.
- R5: Opcode 0101010X issues four steps, in this order: 00001/01; {0001, ~X}/01; 01010/10; {0001, X}/10. X = 0 selects AX (00010) and X = 1 selects BX (00011).
- R6: Any other opcode issues no control word and raises `done` in the cycle after the accepting edge.
- R7: Each step holds its word for TICKS cycles. Tick indices 0..TICKS-1 count from the first cycle after the accepting edge, or after a gap. `bus_clk` is low on ticks below CLK_TICK (default 2, the third tick) and high from CLK_TICK to the end of the step. `bus_clk` is never high while idle.
- R8: Between two consecutive steps there is exactly one cycle with `busy` high, word 00000/00 and `bus_clk` low.
- R9: `done` is a single-cycle pulse in the cycle after a procedure's last step, with `busy` low in that cycle. `busy` is high from the first step cycle through the last step cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a procedure for `opcode` |
| opcode | input | 8 | Fetched instruction, sampled with `start` |
| ctl_enum | output | 5 | Control-bus enumerator of the current step |
| ctl_param | output | 2 | Control-bus parameter of the current step |
| bus_clk | output | 1 | Derived bus clock, high in the late part of each step |
| busy | output | 1 | A procedure is in progress |
| done | output | 1 | One-cycle end-of-procedure pulse |

## Verification
The properties place no condition on `start` or `opcode`. Either may change in any cycle, and the properties relate only the outputs, together with `start` at the edge where `busy` rises. They rely on TICKS being larger than CLK_TICK and on CLK_TICK being at least 1, so every step has settled ticks before the bus clock rises and ends with it high. The bench changes inputs only on the falling clock edge. It sweeps all 256 opcodes twice: once with `start` dropped after acceptance, and once with `start` held high and the opcode inverted for the whole procedure, then released in the `done` cycle so that no second procedure is launched.

// File: rtl/mseq_pkg.sv
// Package: shared widths, the control-word type and sequencer state encoding.
// Assumes an 8-bit instruction and a control word of 5 enumerator bits plus
// 2 parameter bits; these widths are fixed by the bus the block drives.
package mseq_pkg;

    localparam int OPC_W      = 8;
    localparam int ENUM_W     = 5;
    localparam int PARM_W     = 2;
    localparam int MAX_STEPS  = 4;
    localparam int STEP_IDX_W = $clog2(MAX_STEPS);
    localparam int CNT_W      = $clog2(MAX_STEPS + 1);

    // Field positions within a move opcode (decoded by the register file).
    localparam int MOV_SRC_LSB = 3;
    localparam int MOV_DST_LSB = 0;
    localparam int REG_SEL_W   = 3;

    // One control-bus word.
    typedef struct packed {
        logic [ENUM_W-1:0] enm;
        logic [PARM_W-1:0] prm;
    } ctl_word_t;

    // Sequencer phases.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ACT  = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

    // Fixed enumerators used by the increment procedure.
    localparam logic [ENUM_W-1:0] EN_FLAGS   = 5'b00001;
    localparam logic [ENUM_W-1:0] EN_ADD     = 5'b01010;
    localparam logic [ENUM_W-2:0] EN_AB_BASE = 4'b0001;

    // Parameter codes.
    localparam logic [PARM_W-1:0] PR_SRC     = 2'b00;
    localparam logic [PARM_W-1:0] PR_LOW     = 2'b01;
    localparam logic [PARM_W-1:0] PR_DST     = 2'b10;

    // Increment opcode pattern, bit 0 chooses the result register.
    localparam logic [OPC_W-2:0] INC_PATTERN = 7'b0101010;

endpackage

// File: rtl/mseq_opcode_decoder.sv
// Module: mseq_opcode_decoder
// Purely combinational. Maps one opcode onto a step count and a table of up to
// MAX_STEPS control words. Unused table slots are zero. Assumes the caller
// holds the opcode stable while a procedure runs.
module mseq_opcode_decoder
    import mseq_pkg::*;
(
    input  logic [OPC_W-1:0]               opc,
    output logic [CNT_W-1:0]               n_steps,
    output ctl_word_t [MAX_STEPS-1:0]      words
);

    logic is_mov;
    logic is_inc;
    logic inc_sel;
    logic [REG_SEL_W-1:0] mov_src;
    logic [REG_SEL_W-1:0] mov_dst;

    // Classify the opcode into move, increment or neither.
    always_comb begin
        is_mov  = (opc[OPC_W-1 -: 2] == 2'b00) && (opc != '0);
        is_inc  = (opc[OPC_W-1:1] == INC_PATTERN);
        inc_sel = opc[0];
        mov_src = opc[MOV_SRC_LSB +: REG_SEL_W];
        mov_dst = opc[MOV_DST_LSB +: REG_SEL_W];
    end

    // Build the step table for the recognised procedure.
    always_comb begin
        n_steps = '0;
        words   = '0;
        if (is_mov) begin
            n_steps      = CNT_W'(2);
            words[0].enm = {{(ENUM_W-REG_SEL_W){1'b0}}, mov_src};
            words[0].prm = PR_SRC;
            words[1].enm = {{(ENUM_W-REG_SEL_W){1'b0}}, mov_dst};
            words[1].prm = PR_DST;
        end else if (is_inc) begin
            n_steps      = CNT_W'(4);
            words[0].enm = EN_FLAGS;
            words[0].prm = PR_LOW;
            words[1].enm = {EN_AB_BASE, ~inc_sel};
            words[1].prm = PR_LOW;
            words[2].enm = EN_ADD;
            words[2].prm = PR_DST;
            words[3].enm = {EN_AB_BASE, inc_sel};
            words[3].prm = PR_DST;
        end
    end

endmodule

// File: rtl/mseq_step_timer.sv
// Module: mseq_step_timer
// Counts the ticks of the active step. The count restarts at zero whenever the
// step is not active. The module flags the final tick and derives the bus clock,
// which is high from tick CLK_TICK onward. Assumes TICKS > CLK_TICK >= 1.
module mseq_step_timer #(
    parameter int TICKS    = 4,
    parameter int CLK_TICK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic last_tick,
    output logic bus_clk
);

    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);
    localparam logic [TW-1:0] TICK_CLK  = TW'(CLK_TICK);

    logic [TW-1:0] tick_q;

    // Advance within an active step; restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (act && (tick_q != TICK_LAST)) begin
            tick_q <= tick_q + 1'b1;
        end else begin
            tick_q <= '0;
        end
    end

    // Flag the last tick and form the bus clock level.
    always_comb begin
        last_tick = act && (tick_q == TICK_LAST);
        bus_clk   = act && (tick_q >= TICK_CLK);
    end

endmodule

// File: rtl/mseq_proc_fsm.sv
// Module: mseq_proc_fsm
// Control for one procedure: accepts start while idle, runs steps in order with
// a one-cycle gap between them, and pulses done after the last one. A zero-step
// opcode pulses done straight from idle. Assumes n_now is the decode of the
// opcode presented at the accepting edge.
module mseq_proc_fsm
    import mseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [OPC_W-1:0]      opcode,
    input  logic [CNT_W-1:0]      n_now,
    input  logic                  last_tick,
    output seq_state_e            state,
    output logic [STEP_IDX_W-1:0] step_idx,
    output logic [OPC_W-1:0]      opc_held,
    output logic                  done
);

    seq_state_e            state_q;
    logic [STEP_IDX_W-1:0] step_q;
    logic [CNT_W-1:0]      nsteps_q;
    logic [OPC_W-1:0]      opc_q;
    logic                  done_q;
    logic                  final_step;

    // Detect that the running step is the last of the procedure.
    always_comb begin
        final_step = ({1'b0, step_q} == (nsteps_q - CNT_W'(1)));
    end

    // Phase, step index, held opcode and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            step_q   <= '0;
            nsteps_q <= '0;
            opc_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        if (n_now == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q  <= SQ_ACT;
                            step_q   <= '0;
                            nsteps_q <= n_now;
                            opc_q    <= opcode;
                        end
                    end
                end
                SQ_ACT: begin
                    if (last_tick) begin
                        if (final_step) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    state_q <= SQ_ACT;
                    step_q  <= step_q + 1'b1;
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    // Drive outputs from the registered state.
    always_comb begin
        state    = state_q;
        step_idx = step_q;
        opc_held = opc_q;
        done     = done_q;
    end

endmodule

// File: rtl/microstep_sequencer.sv
// Module: microstep_sequencer (top)
// Expands a fetched opcode into a timed list of control-bus words. While idle
// the decoder looks at the incoming opcode; once a procedure runs, it reads
// the held copy. The active word is chosen by step index; outside active
// steps the bus carries zero. Assumes TICKS >= 4 and TICKS > CLK_TICK >= 1.
module microstep_sequencer
    import mseq_pkg::*;
#(
    parameter int TICKS    = 4,
    parameter int CLK_TICK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ENUM_W-1:0] ctl_enum,
    output logic [PARM_W-1:0] ctl_param,
    output logic              bus_clk,
    output logic              busy,
    output logic              done
);

    seq_state_e                state;
    logic [STEP_IDX_W-1:0]     step_idx;
    logic [OPC_W-1:0]          opc_held;
    logic [OPC_W-1:0]          dec_opc;
    logic [CNT_W-1:0]          n_steps;
    ctl_word_t [MAX_STEPS-1:0] words;
    ctl_word_t [MAX_STEPS-1:0] gated;
    logic                      act;
    logic                      last_tick;
    logic                      timer_clk;

    // Pick the opcode the decoder sees: live while idle, held while running.
    always_comb begin
        dec_opc = (state == SQ_IDLE) ? opcode : opc_held;
        act     = (state == SQ_ACT);
    end

    mseq_opcode_decoder u_dec (
        .opc     (dec_opc),
        .n_steps (n_steps),
        .words   (words)
    );

    mseq_step_timer #(
        .TICKS    (TICKS),
        .CLK_TICK (CLK_TICK)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .last_tick (last_tick),
        .bus_clk   (timer_clk)
    );

    mseq_proc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .n_now     (n_steps),
        .last_tick (last_tick),
        .state     (state),
        .step_idx  (step_idx),
        .opc_held  (opc_held),
        .done      (done)
    );

    // Gate each table slot so only the current active step reaches the bus.
    for (genvar gi = 0; gi < MAX_STEPS; gi++) begin : g_slot
        always_comb begin
            gated[gi] = (act && (step_idx == STEP_IDX_W'(gi))) ? words[gi] : '0;
        end
    end

    // Merge the gated slots onto the bus and form the status outputs.
    always_comb begin
        ctl_word_t merged;
        merged = '0;
        for (int i = 0; i < MAX_STEPS; i++) begin
            merged = merged | gated[i];
        end
        ctl_enum  = merged.enm;
        ctl_param = merged.prm;
        bus_clk   = timer_clk;
        busy      = (state != SQ_IDLE);
    end

endmodule

// File: rtl/mseq_checker.sv
// Module: mseq_checker
// Temporal properties over the sequencer ports; attached with bind below.
module mseq_checker
    import mseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ENUM_W-1:0] ctl_enum,
    input logic [PARM_W-1:0] ctl_param,
    input logic              bus_clk,
    input logic              busy,
    input logic              done
);

    // R1: an idle block keeps the bus quiet.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctl_enum == '0 && ctl_param == '0 && !bus_clk));

    // R2: a procedure only begins when start was seen.
    a_r2_start_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: bus clock only inside a procedure.
    a_r7_clk_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk |-> busy);

    // R7: the word has settled before the bus clock rises.
    a_r7_word_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> ($stable(ctl_enum) && $stable(ctl_param) && busy));

    // R8: once a step ends, the bus returns to zero.
    a_r8_clk_fall_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clk) |-> (ctl_enum == '0 && ctl_param == '0));

    // R9: done appears only while idle.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: done follows either a running procedure or an accepted start.
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

endmodule

bind microstep_sequencer mseq_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ctl_enum  (ctl_enum),
    .ctl_param (ctl_param),
    .bus_clk   (bus_clk),
    .busy      (busy),
    .done      (done)
);

// File: tb/microstep_sequencer_tb_top.sv
// Bench: sweeps all opcodes in two start patterns and compares every cycle of
// every procedure against a model computed from the requirements.
module microstep_sequencer_tb_top;

    localparam int TICKS    = 5;
    localparam int CLK_TICK = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] opcode;
    logic [4:0] ctl_enum;
    logic [1:0] ctl_param;
    logic       bus_clk;
    logic       busy;
    logic       done;

    int vectors   = 0;
    int miscomp   = 0;
    bit finished  = 1'b0;

    int         exp_n;
    logic [6:0] exp_w [4];
    string      cls_tag;

    always #10 clk = ~clk;

    microstep_sequencer #(
        .TICKS    (TICKS),
        .CLK_TICK (CLK_TICK)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .ctl_enum  (ctl_enum),
        .ctl_param (ctl_param),
        .bus_clk   (bus_clk),
        .busy      (busy),
        .done      (done)
    );

    // Expected step list from the requirement text.
    task automatic model(input logic [7:0] o);
        for (int i = 0; i < 4; i++) exp_w[i] = '0;
        if (o == 8'h00) begin
            exp_n = 0; cls_tag = "R4";
        end else if (o[7:6] == 2'b00) begin
            exp_n    = 2; cls_tag = "R3";
            exp_w[0] = {2'b00, o[5:3], 2'b00};
            exp_w[1] = {2'b00, o[2:0], 2'b10};
        end else if (o[7:1] == 7'b0101010) begin
            exp_n    = 4; cls_tag = "R5";
            exp_w[0] = {5'd1, 2'b01};
            exp_w[1] = {5'd2 + (o[0] ? 5'd0 : 5'd1), 2'b01};
            exp_w[2] = {5'd10, 2'b10};
            exp_w[3] = {5'd2 + {4'd0, o[0]}, 2'b10};
        end else begin
            exp_n = 0; cls_tag = "R6";
        end
    endtask

    // Compare one cycle of outputs, then move to the next falling edge.
    task automatic chk(input string tag, input logic b, input logic d,
                       input logic c, input logic [6:0] w);
        logic [9:0] act_v;
        logic [9:0] exp_v;
        act_v = {busy, done, bus_clk, ctl_enum, ctl_param};
        exp_v = {b, d, c, w};
        vectors++;
        if (act_v !== exp_v) begin
            miscomp++;
            $display("FAIL %s opcode=%02h busy/done/clk/enum/param act=%b exp=%b",
                     tag, opcode, act_v, exp_v);
        end
        @(negedge clk);
    endtask

    // Run one opcode; with r2 set, start stays high and the opcode is inverted.
    task automatic run_op(input logic [7:0] o, input bit r2);
        model(o);
        start  = 1'b1;
        opcode = o;
        @(negedge clk);
        if (r2) opcode = ~o;
        else    start  = 1'b0;
        if (exp_n == 0) begin
            start = 1'b0;
            chk(cls_tag, 1'b0, 1'b1, 1'b0, 7'd0);
        end else begin
            for (int s = 0; s < exp_n; s++) begin
                for (int t = 0; t < TICKS; t++) begin
                    chk(r2 ? "R2" : ((t < CLK_TICK) ? cls_tag : "R7"),
                        1'b1, 1'b0, (t >= CLK_TICK), exp_w[s]);
                end
                if (s < exp_n - 1) chk("R8", 1'b1, 1'b0, 1'b0, 7'd0);
            end
            start = 1'b0;
            chk("R9", 1'b0, 1'b1, 1'b0, 7'd0);
        end
        chk("R9", 1'b0, 1'b0, 1'b0, 7'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscomp++;
            $display("FAIL R9 watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        rst_n  = 1'b0;
        start  = 1'b1;
        opcode = 8'h55;
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b0, 7'd0);
        rst_n = 1'b1;
        start = 1'b0;
        chk("R1", 1'b0, 1'b0, 1'b0, 7'd0);
        for (int pass = 0; pass < 2; pass++) begin
            for (int o = 0; o < 256; o++) begin
                run_op(8'(o), pass == 1);
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule